// File: doc/BRIEF.md
# Serial Wiper Code Loader

This block is the digital front end of a 256-tap digital potentiometer. A host writes the wiper position over a receive-only, three-wire serial link made of an active-low select, a serial clock and a data line. All three pins are asynchronous to the block. They are brought into the system clock domain through two-flop synchronisers, and edges are detected on the synchronised copies. The system clock must run at least four times faster than the serial clock.

While select is low, each rising serial-clock edge shifts one data bit into a shift register, most significant bit first. The shift register is never cleared. When select returns high, its content is copied into the wiper register. The wiper register drives the code output, a one-hot tap select and a flag that marks the position where the wiper touches the B-terminal contact. A single-cycle strobe reports every load that changes the code. After reset the wiper sits at midscale.

Top module: `wiper_spi_rx`

## Requirements
- R1: Bits enter MSB first. After exactly 8 serial clocks in one frame, the first bit sent is bit 7 of the code and the last bit sent is bit 0.
- R2: A bit is captured only on a rising serial-clock edge seen while the synchronised select is low. The shift register content becomes the wiper code when select rises.
- R3: While a frame is in progress, the code output keeps its previous value until select rises.
- R4: If a frame has more than 8 serial clocks, only the last 8 bits received form the code. The earlier bits are lost.
- R5: After reset the code is 0x80, the shift register holds 0x00, and the strobe is low.
- R6: A frame with fewer than 8 clocks, including a frame with none, still loads on select rising. The new code is the previous shift content moved up by the number of bits received, with those bits appended at the bottom.
- R7: The tap select has exactly one bit set, and that bit's index equals the code (bit 0 for 0x00, bit 255 for 0xFF).
- R8: The B-contact flag is high exactly when the code is 0x00.
- R9: The update strobe is high for one cycle, in the same cycle the new code first appears, and only when the loaded code differs from the old one.
- R10: Serial-clock edges while select is high change neither the shift register nor the code.
- R11: The new code appears after the third system clock edge that samples select high. Edges are counted from the first edge at which select is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| code | output | 8 | Wiper register value |
| tap_sel | output | 256 | One-hot tap enable, bit index equals code |
| at_b | output | 1 | High when the wiper is at the B-terminal contact |
| upd | output | 1 | One-cycle pulse when the code changes |

## Verification
The bench sends several kinds of frame:
- A plain 8-bit word, which checks bit order and that the code does not move mid-frame.
- A 12-bit overlong word, which shows that only the trailing byte is kept.
- A 3-bit short frame and a frame with no clocks, which show that the shift register is carried over rather than cleared.
- A burst of serial clocks with select high, which shows that such edges are ignored.

The extreme codes 0x00 and 0xFF exercise both ends of the tap decoder and the B-contact flag. Reloading the same code shows that the strobe stays low. An edge-counted load confirms the exact three-edge latency.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Snapshot of the three serial pins as seen by the system clock.
  typedef struct packed {
    logic sel_n;
    logic sck;
    logic sdi;
  } pins_t;

  // Idle level the synchroniser and edge history reset to.
  localparam pins_t PINS_IDLE = '{sel_n: 1'b1, sck: 1'b0, sdi: 1'b0};

  // Events derived from the synchronised pins for one system cycle.
  typedef struct packed {
    logic sck_rise;
    logic sel_rise;
    logic sel_active;
    logic data_bit;
  } evt_t;

endpackage

// File: rtl/wsr_sync.sv
// Multi-stage synchroniser for the three serial pins.
module wsr_sync
  import wiper_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t raw,
  output pins_t synced
);

  pins_t [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= PINS_IDLE;
    end else begin
      stg_q[0] <= raw;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign synced = stg_q[STAGES-1];

endmodule

// File: rtl/wsr_events.sv
// Edge detection on the synchronised pins.
module wsr_events
  import wiper_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t synced,
  output evt_t  evt
);

  pins_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= PINS_IDLE;
    else        prev_q <= synced;
  end

  function automatic logic rise_of(input logic now_v, input logic was_v);
    return now_v & ~was_v;
  endfunction

  always_comb begin
    evt.sel_active = ~synced.sel_n;
    evt.sel_rise   = rise_of(synced.sel_n, prev_q.sel_n);
    evt.sck_rise   = rise_of(synced.sck, prev_q.sck);
    evt.data_bit   = synced.sdi;
  end

endmodule

// File: rtl/wsr_shift.sv
// Serial input shift register; never cleared between frames.
module wsr_shift #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] q
);

  function automatic logic [WIDTH-1:0] push_lsb(input logic [WIDTH-1:0] cur,
                                                input logic b);
    return {cur[WIDTH-2:0], b};
  endfunction

  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= push_lsb(sr_q, din);
  end

  assign q = sr_q;

endmodule

// File: rtl/wsr_tapdec.sv
// Code to one-hot tap enable plus B-contact flag.
module wsr_tapdec #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned TAPS = 1 << WIDTH
) (
  input  logic [WIDTH-1:0] code,
  output logic [TAPS-1:0]  tap_sel,
  output logic             at_b
);

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tap_sel[g] = (code == WIDTH'(g));
  end

  // Tap zero is the contact that sits on the B terminal.
  assign at_b = tap_sel[0];

endmodule

// File: rtl/wiper_spi_rx.sv
// Top: serial wiper code loader.
module wiper_spi_rx
  import wiper_pkg::*;
#(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TAPS       = 1 << CODE_W,
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [CODE_W-1:0] code,
  output logic [TAPS-1:0]   tap_sel,
  output logic              at_b,
  output logic              upd
);

  // Named internal events, visible to the bound checker.
  pins_t            pins_raw;
  pins_t            pins_sync;
  evt_t             evt;
  logic             sel_rise;
  logic             sck_rise;
  logic             sel_active;
  logic             shift_en;
  logic [CODE_W-1:0] shift_q;
  logic [CODE_W-1:0] wiper_q;
  logic             code_differs;
  logic             upd_q;

  assign pins_raw = '{sel_n: sel_n, sck: sclk, sdi: sdi};

  wsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (pins_raw),
    .synced (pins_sync)
  );

  wsr_events u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .synced (pins_sync),
    .evt    (evt)
  );

  assign sel_rise   = evt.sel_rise;
  assign sck_rise   = evt.sck_rise;
  assign sel_active = evt.sel_active;
  assign shift_en   = sck_rise & sel_active;

  wsr_shift #(.WIDTH(CODE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (evt.data_bit),
    .q        (shift_q)
  );

  // Wiper register: loaded only on the select rising edge.
  assign code_differs = (shift_q != wiper_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= MID_CODE;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= sel_rise & code_differs;
      if (sel_rise) wiper_q <= shift_q;
    end
  end

  wsr_tapdec #(.WIDTH(CODE_W)) u_dec (
    .code    (wiper_q),
    .tap_sel (tap_sel),
    .at_b    (at_b)
  );

  assign code = wiper_q;
  assign upd  = upd_q;

endmodule

// File: rtl/wiper_spi_chk.sv
module wiper_spi_chk #(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned TAPS  = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code,
  input logic [TAPS-1:0]   tap_sel,
  input logic              at_b,
  input logic              upd,
  input logic              sel_rise,
  input logic              sck_rise,
  input logic              sel_active,
  input logic [CODE_W-1:0] shift_q
);

  assert_shift_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && sel_active) |=> shift_q[CODE_W-1:1] == $past(shift_q[CODE_W-2:0]));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> code == $past(shift_q));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_rise |=> $stable(code));

  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1 && tap_sel[code]);

  assert_b_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    at_b == (code == '0));

  assert_strobe_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> code != $past(code));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  assert_ignore_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && !sel_active) |=> $stable(shift_q));

endmodule

bind wiper_spi_rx wiper_spi_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code       (code),
  .tap_sel    (tap_sel),
  .at_b       (at_b),
  .upd        (upd),
  .sel_rise   (sel_rise),
  .sck_rise   (sck_rise),
  .sel_active (sel_active),
  .shift_q    (shift_q)
);

// File: tb/test_wiper_spi_rx.sv
`timescale 1ns/1ps
module test_wiper_spi_rx;

  localparam int TAPS = 256;
  localparam int HALF = 4;   // serial half period in system cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [7:0] code;
  logic [TAPS-1:0] tap_sel;
  logic at_b;
  logic upd;

  int n_chk = 0;
  int n_fail = 0;
  int n_upd = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  wiper_spi_rx i_wiper_spi_rx (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .code(code), .tap_sel(tap_sel), .at_b(at_b), .upd(upd)
  );

  task automatic chk(input string tag, input logic [TAPS-1:0] act,
                     input logic [TAPS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [TAPS-1:0] onehot(input logic [7:0] c);
    logic [TAPS-1:0] v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  // Behavioural reference: pin history queues with the sampling latency.
  bit q_sel[$];
  bit q_sck[$];
  bit q_sdi[$];
  logic [7:0] m_sh, m_wp;
  bit m_upd;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_sel = '{1, 1, 1, 1};
      q_sck = '{0, 0, 0, 0};
      q_sdi = '{0, 0, 0, 0};
      m_sh = 8'h00;
      m_wp = 8'h80;
      m_upd = 0;
    end else begin
      q_sel.push_back(sel_n); void'(q_sel.pop_front());
      q_sck.push_back(sclk);  void'(q_sck.pop_front());
      q_sdi.push_back(sdi);   void'(q_sdi.pop_front());
      m_upd = 0;
      if (q_sel[1] && !q_sel[0]) begin
        m_upd = (m_sh != m_wp);
        m_wp = m_sh;
      end else if (!q_sel[1] && q_sck[1] && !q_sck[0]) begin
        m_sh = {m_sh[6:0], q_sdi[1]};
      end
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 code vs model", TAPS'(code), TAPS'(m_wp));
      chk("R7 tap vs model", tap_sel, onehot(m_wp));
      chk("R8 flag vs model", TAPS'(at_b), TAPS'(m_wp == 8'h00));
      chk("R9 strobe vs model", TAPS'(upd), TAPS'(m_upd));
      if (upd) n_upd++;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame();
    @(negedge clk); sel_n = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdi = bits[i]; sclk = 1'b0;
      wait_cyc(HALF);
      sclk = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic close_frame();
    wait_cyc(HALF);
    sel_n = 1'b1;
    wait_cyc(10);
  endtask

  initial begin
    int u0;
    wait_cyc(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset code", TAPS'(code), TAPS'(8'h80));
    chk("R5 reset tap", tap_sel, TAPS'(1) << 128);
    chk("R5 reset flag", TAPS'(at_b), '0);
    chk("R5 reset strobe", TAPS'(upd), '0);

    // Plain word, MSB first
    u0 = n_upd;
    open_frame(); send_bits(32'h3C, 8);
    chk("R3 code held mid-frame", TAPS'(code), TAPS'(8'h80));
    close_frame();
    chk("R1 MSB-first word", TAPS'(code), TAPS'(8'h3C));
    chk("R9 one pulse on change", TAPS'(n_upd - u0), TAPS'(1));

    // Overlong frame keeps trailing byte
    open_frame(); send_bits(32'hFA5, 12); close_frame();
    chk("R4 last 8 bits kept", TAPS'(code), TAPS'(8'hA5));

    // Clocks with select high, then an empty frame exposes the shift register
    u0 = n_upd;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); sdi = k[0]; sclk = 1'b1;
      wait_cyc(HALF); sclk = 1'b0; wait_cyc(HALF);
    end
    chk("R10 code unchanged by idle clocks", TAPS'(code), TAPS'(8'hA5));
    open_frame(); close_frame();
    chk("R10 shift unchanged by idle clocks", TAPS'(code), TAPS'(8'hA5));
    chk("R9 no pulse on equal reload", TAPS'(n_upd - u0), '0);

    // Short frame: 3 bits appended to previous content
    open_frame(); send_bits(32'h5, 3); close_frame();
    chk("R6 short frame", TAPS'(code), TAPS'(8'h2D));

    // Extremes of the decoder
    open_frame(); send_bits(32'h00, 8); close_frame();
    chk("R8 flag at zero", TAPS'(at_b), TAPS'(1));
    chk("R7 tap zero", tap_sel, TAPS'(1));
    open_frame(); send_bits(32'hFF, 8); close_frame();
    chk("R7 tap top", tap_sel, TAPS'(1) << 255);
    chk("R8 flag off at top", TAPS'(at_b), '0);
    u0 = n_upd;
    open_frame(); send_bits(32'hFF, 8); close_frame();
    chk("R9 no pulse same code", TAPS'(n_upd - u0), '0);

    // Exact load latency
    open_frame(); send_bits(32'h5A, 8); wait_cyc(HALF);
    sel_n = 1'b1;
    wait_cyc(2);
    chk("R11 code old after two edges", TAPS'(code), TAPS'(8'hFF));
    wait_cyc(1);
    chk("R11 code new after third edge", TAPS'(code), TAPS'(8'h5A));
    chk("R9 strobe with new code", TAPS'(upd), TAPS'(1));
    wait_cyc(1);
    chk("R9 strobe one cycle", TAPS'(upd), '0);
    wait_cyc(10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule